// File: doc/BRIEF.md
# TDM Time-Slot Serial Transmitter

This block places one byte per frame into a chosen time slot of a time-division multiplexed serial line. All of its logic runs on a fast master clock. It oversamples an external bit clock and a frame sync through short synchronizer chains and reacts to the bit-clock edge chosen for launching data. Each frame sync, as seen on a launch edge, restarts a bit-position counter. When the counter reaches the configured slot start, the next eight launch edges send the byte, one bit per edge.

There are two serial data outputs, each with its own output enable, so the line can be driven in 3-state fashion. When both are enabled they carry the same bits at the same time. In strobe mode the second output is always driven and acts as an active-low timing strobe. An external line driver can use it to know when the first output holds valid bits. Bytes arrive through a valid/ready load port and wait in a single holding register until their slot. If no byte is waiting when a slot begins, the previous byte is sent again and an underrun pulse is raised.

Top module: `tdm_slot_tx`

## Requirements
- R1: With `cfg_launch_rise` = 0, bits are launched on falling edges of `bclk`. With `cfg_launch_rise` = 1, they are launched on rising edges. The outputs change only a few master-clock cycles after a launch edge and hold their values until the next one.
- R2: A launch edge that sees `fsync` high, where the previous launch edge saw it low, sets the bit position to 0. Every other launch edge adds one to the position, which saturates at its maximum.
- R3: The byte occupies bit positions S to S+7, where S = `cfg_slot`*8 + `cfg_bit_off`. `txa_oe` is 1 exactly for those positions when `cfg_en_a` = 1.
- R4: When an output enable is 0, the matching data output is 1. A data output with its enable cleared never has its output enable raised.
- R5: With `cfg_msb_first` = 0, byte bit 0 is sent at position S and bit k at position S+k. With `cfg_msb_first` = 1, bit 7 is sent first and bit 7-k at position S+k.
- R6: With `cfg_invert` = 1, every transmitted data bit is complemented.
- R7: With `cfg_strobe_b` = 0 and `cfg_en_b` = 1, `txb_oe`/`txb_data` follow the same window and carry the same bits as the first output would.
- R8: With `cfg_strobe_b` = 1, `txb_oe` is 1 on every launch edge after the mode is set. `txb_data` is 0 during the bit positions in which the first output is enabled and sending, and 1 otherwise, regardless of `cfg_en_b`.
- R9: `ld_ready` is 1 exactly when no byte is waiting. A byte is taken on a clock edge with `ld_valid` and `ld_ready` both high. A byte offered while `ld_ready` is 0 is ignored.
- R10: At a slot start with no byte waiting, the previous byte is sent again and `underrun` pulses high for one master-clock cycle. The waiting byte is used otherwise.
- R11: After reset the outputs are idle (both enables 0, both data outputs 1), `ld_ready` is 1, and `underrun` is 0. No output enable rises before the first frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, more than twice the bit clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | External bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, sampled on the launch edge |
| cfg_launch_rise | input | 1 | 1 selects the rising bit-clock edge for launch |
| cfg_invert | input | 1 | Complement transmitted bits |
| cfg_msb_first | input | 1 | 1 sends bit 7 first, 0 sends bit 0 first |
| cfg_slot | input | SLOT_W | Slot number of the byte |
| cfg_bit_off | input | log2(DATA_W) | Extra bit offset added to the slot start |
| cfg_en_a | input | 1 | Enable first data output |
| cfg_en_b | input | 1 | Enable second data output |
| cfg_strobe_b | input | 1 | Second output becomes active-low valid strobe |
| ld_valid | input | 1 | Load request |
| ld_data | input | DATA_W | Byte to load |
| ld_ready | output | 1 | Holding register empty |
| txa_data | output | 1 | First serial data output |
| txa_oe | output | 1 | Output enable for txa_data |
| txb_data | output | 1 | Second serial data output or strobe |
| txb_oe | output | 1 | Output enable for txb_data |
| underrun | output | 1 | One-cycle pulse when a slot repeats the old byte |

## Verification
The assertions check, on every master-clock cycle, properties that hold across cycles. A launch edge is never flagged on two cycles in a row. The bit position only grows between syncs. The pins hold still between launch edges. A disabled output never raises its enable. The strobe is the complement of the first enable. The holding register's ready flag drops after each load, and underrun pulses last one cycle. Some behaviours can only be shown by the bench's frame scenarios, where the bench models the slot arithmetic, bit order, inversion and byte repetition itself. These are: the exact slot position, which byte bit appears at each position, the choice of launch edge, and whether a byte offered while the register is full is dropped.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    // Per-bit shaping and routing controls
    typedef struct packed {
        logic invert;
        logic msb_first;
        logic en_a;
        logic en_b;
        logic strobe_b;
    } tx_mode_t;

    // Registered pin state of both serial outputs
    typedef struct packed {
        logic a_dat;
        logic a_oe;
        logic b_dat;
        logic b_oe;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{a_dat: 1'b1, a_oe: 1'b0, b_dat: 1'b1, b_oe: 1'b0};

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic launch_rise,
    output logic launch,
    output logic restart
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bsh;
        logic [SYNC_STAGES-1:0] fsh;
        logic                   bprev;
        logic                   fs_last;
    } st_t;

    localparam st_t ST_RESET = '0;

    st_t st_q, st_d;
    logic cur_b, cur_f, rise_seen, fall_seen;

    initial begin
        if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
    end

    always_comb begin
        st_d      = st_q;
        st_d.bsh  = {st_q.bsh[SYNC_STAGES-2:0], bclk};
        st_d.fsh  = {st_q.fsh[SYNC_STAGES-2:0], fsync};
        cur_b     = st_q.bsh[SYNC_STAGES-1];
        cur_f     = st_q.fsh[SYNC_STAGES-1];
        st_d.bprev = cur_b;
        rise_seen = cur_b & ~st_q.bprev;
        fall_seen = ~cur_b & st_q.bprev;
        launch    = launch_rise ? rise_seen : fall_seen;
        restart   = launch & cur_f & ~st_q.fs_last;
        if (launch) begin
            st_d.fs_last = cur_f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // A launch edge is a single-cycle event
    assert_launch_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter  int DATA_W = 8,
    parameter  int SLOT_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int POS_W  = SLOT_W + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  bit_off,
    output logic              first,
    output logic              live,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] SPAN    = POS_W'(DATA_W - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } st_t;

    localparam st_t ST_RESET = '{pos: POS_MAX};

    st_t st_q, st_d;
    logic [POS_W-1:0] start_p, stop_p, delta;

    always_comb begin
        st_d    = st_q;
        start_p = {1'b0, slot, bit_off};
        stop_p  = start_p + SPAN;
        if (tick) begin
            if (restart)                 st_d.pos = '0;
            else if (st_q.pos != POS_MAX) st_d.pos = st_q.pos + 1'b1;
        end
        delta = st_d.pos - start_p;
        idx   = delta[IDX_W-1:0];
        live  = (st_d.pos >= start_p) && (st_d.pos <= stop_p);
        first = tick && (st_d.pos == start_p);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // Position only moves forward unless a sync restarts it
    assert_pos_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (st_q.pos >= $past(st_q.pos)));

    // A restart always lands on position zero
    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> (st_q.pos == '0));

endmodule

// File: rtl/tdm_byte_hold.sv
module tdm_byte_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              consume,
    output logic              ld_ready,
    output logic [DATA_W-1:0] byte_now,
    output logic              underrun
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] cur;
        logic              full;
        logic              urun;
    } st_t;

    localparam st_t ST_RESET = '0;

    st_t st_q, st_d;
    logic accept;

    always_comb begin
        st_d      = st_q;
        st_d.urun = 1'b0;
        ld_ready  = ~st_q.full;
        accept    = ld_valid & ~st_q.full;
        if (consume) begin
            if (st_q.full) st_d.cur = st_q.hold;
            st_d.urun = ~st_q.full;
            st_d.full = 1'b0;
        end
        if (accept) begin
            st_d.hold = ld_data;
            st_d.full = 1'b1;
        end
        byte_now = st_d.cur;
        underrun = st_q.urun;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready);

    assert_underrun_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

// File: rtl/tdm_bit_drive.sv
module tdm_bit_drive
    import tdm_tx_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              live,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] byte_now,
    input  tx_mode_t          mode,
    output pin_set_t          pins
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        pin_set_t p;
    } st_t;

    localparam st_t ST_RESET = '{p: PINS_IDLE};

    st_t st_q, st_d;
    logic [IDX_W-1:0] pick;
    logic bitv, a_on, b_on;

    always_comb begin
        st_d = st_q;
        pick = mode.msb_first ? (TOP_IDX - idx) : idx;
        bitv = byte_now[pick] ^ mode.invert;
        a_on = live & mode.en_a;
        b_on = live & mode.en_b;
        if (tick) begin
            st_d.p.a_oe  = a_on;
            st_d.p.a_dat = a_on ? bitv : 1'b1;
            if (mode.strobe_b) begin
                st_d.p.b_oe  = 1'b1;
                st_d.p.b_dat = ~a_on;
            end else begin
                st_d.p.b_oe  = b_on;
                st_d.p.b_dat = b_on ? bitv : 1'b1;
            end
        end
        pins = st_q.p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assert_a_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mode.en_a) |=> !pins.a_oe);

    assert_b_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mode.en_b && !mode.strobe_b) |=> !pins.b_oe);

    assert_strobe_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode.strobe_b) |=> (pins.b_oe && (pins.b_dat != pins.a_oe)));

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter  int DATA_W      = 8,
    parameter  int SLOT_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int OFF_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              cfg_launch_rise,
    input  logic              cfg_invert,
    input  logic              cfg_msb_first,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [OFF_W-1:0]  cfg_bit_off,
    input  logic              cfg_en_a,
    input  logic              cfg_en_b,
    input  logic              cfg_strobe_b,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_ready,
    output logic              txa_data,
    output logic              txa_oe,
    output logic              txb_data,
    output logic              txb_oe,
    output logic              underrun
);

    tx_mode_t          mode;
    pin_set_t          pins;
    logic              launch, restart, first, live;
    logic [OFF_W-1:0]  idx;
    logic [DATA_W-1:0] byte_now;

    always_comb begin
        mode.invert    = cfg_invert;
        mode.msb_first = cfg_msb_first;
        mode.en_a      = cfg_en_a;
        mode.en_b      = cfg_en_b;
        mode.strobe_b  = cfg_strobe_b;
        txa_data       = pins.a_dat;
        txa_oe         = pins.a_oe;
        txb_data       = pins.b_dat;
        txb_oe         = pins.b_oe;
    end

    tdm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .launch_rise(cfg_launch_rise), .launch(launch), .restart(restart)
    );

    tdm_slot_timer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(launch), .restart(restart),
        .slot(cfg_slot), .bit_off(cfg_bit_off),
        .first(first), .live(live), .idx(idx)
    );

    tdm_byte_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
        .consume(first), .ld_ready(ld_ready), .byte_now(byte_now),
        .underrun(underrun)
    );

    tdm_bit_drive #(.DATA_W(DATA_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .tick(launch), .live(live), .idx(idx),
        .byte_now(byte_now), .mode(mode), .pins(pins)
    );

    // Pins move only on the cycle after a launch edge
    assert_pins_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable({txa_data, txa_oe, txb_data, txb_oe}));

    // An underrun can only follow a launch edge
    assert_underrun_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(launch));

endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 40;
    localparam int POS_MAX    = 4095;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b1;
    logic       fsync = 1'b0;
    logic       cfg_launch_rise = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [7:0] cfg_slot = 8'd1;
    logic [2:0] cfg_bit_off = 3'd3;
    logic       cfg_en_a = 1'b1;
    logic       cfg_en_b = 1'b0;
    logic       cfg_strobe_b = 1'b0;
    logic       ld_valid = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic       ld_ready, txa_data, txa_oe, txb_data, txb_oe, underrun;

    int  total = 0;
    int  bad = 0;
    int  ur_seen = 0;
    bit  done = 1'b0;

    // Bench model state
    int         m_pos = POS_MAX;
    bit         m_fs_last = 1'b0;
    bit         m_full = 1'b0;
    logic [7:0] m_hold = 8'h00;
    logic [7:0] m_cur = 8'h00;
    int         m_ur = 0;

    tdm_slot_tx u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .cfg_launch_rise(cfg_launch_rise), .cfg_invert(cfg_invert),
        .cfg_msb_first(cfg_msb_first), .cfg_slot(cfg_slot),
        .cfg_bit_off(cfg_bit_off), .cfg_en_a(cfg_en_a), .cfg_en_b(cfg_en_b),
        .cfg_strobe_b(cfg_strobe_b), .ld_valid(ld_valid), .ld_data(ld_data),
        .ld_ready(ld_ready), .txa_data(txa_data), .txa_oe(txa_oe),
        .txb_data(txb_data), .txb_oe(txb_oe), .underrun(underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n && underrun) ur_seen++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_bit(input logic [7:0] b, input int k, input bit msb, input bit inv);
        return b[msb ? 7 - k : k] ^ inv;
    endfunction

    // One bit-clock period: optional load, sync setup, launch edge, then check
    task automatic bit_period(input bit fs, input bit do_load, input logic [7:0] val);
        int  start;
        bit  win;
        int  k;
        bit  eb, ea_oe, ea_d, eb_oe, eb_d;
        logic pre;
        if (do_load) begin
            ld_valid = 1'b1;
            ld_data  = val;
            check(ld_ready == !m_full, "R9 ready", ld_ready, !m_full);
            wait_neg(1);
            ld_valid = 1'b0;
            if (!m_full) begin
                m_hold = val;
                m_full = 1'b1;
            end
        end
        pre   = cfg_launch_rise ? 1'b0 : 1'b1;
        bclk  = pre;
        fsync = fs;
        wait_neg(8);
        bclk = ~pre;                       // launch edge (R1)
        wait_neg(15);
        // model of R2 / R3 / R10
        start = int'(cfg_slot) * 8 + int'(cfg_bit_off);
        if (fs && !m_fs_last) m_pos = 0;
        else if (m_pos < POS_MAX) m_pos++;
        m_fs_last = fs;
        if (m_pos == start) begin
            if (m_full) begin
                m_cur  = m_hold;
                m_full = 1'b0;
            end else begin
                m_ur++;
            end
        end
        win   = (m_pos >= start) && (m_pos <= start + 7);
        k     = m_pos - start;
        eb    = win ? exp_bit(m_cur, k, cfg_msb_first, cfg_invert) : 1'b1;
        ea_oe = win && cfg_en_a;
        ea_d  = ea_oe ? eb : 1'b1;
        if (cfg_strobe_b) begin
            eb_oe = 1'b1;
            eb_d  = !ea_oe;
        end else begin
            eb_oe = win && cfg_en_b;
            eb_d  = eb_oe ? eb : 1'b1;
        end
        check(txa_oe == ea_oe, "R3 txa_oe window", txa_oe, ea_oe);
        check(txa_data == ea_d, "R5 R6 R4 txa_data", txa_data, ea_d);
        check(txb_oe == eb_oe, cfg_strobe_b ? "R8 txb_oe" : "R7 txb_oe", txb_oe, eb_oe);
        check(txb_data == eb_d, cfg_strobe_b ? "R8 strobe level" : "R7 txb_data", txb_data, eb_d);
        check(ur_seen == m_ur, "R10 underrun count", ur_seen, m_ur);
        wait_neg(1);
    endtask

    task automatic frame(input bit load0, input logic [7:0] v0, input bit load1, input logic [7:0] v1);
        for (int p = 0; p < FRAME_LEN; p++) begin
            bit dl;
            logic [7:0] dv;
            dl = (p == 0 && load0) || (p == 2 && load1);
            dv = (p == 0) ? v0 : v1;
            bit_period(p == 0, dl, dv);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_neg(3);
        // R11: reset state
        check(txa_oe == 1'b0 && txb_oe == 1'b0, "R11 reset oe", {txa_oe, txb_oe}, 0);
        check(txa_data == 1'b1 && txb_data == 1'b1, "R11 reset data", {txa_data, txb_data}, 3);
        check(ld_ready == 1'b1 && underrun == 1'b0, "R11 reset ready", {ld_ready, underrun}, 2);
        rst_n = 1'b1;
        wait_neg(3);

        // R11: no output before a frame sync, even with a byte waiting
        bit_period(1'b0, 1'b1, 8'hA5);
        for (int i = 0; i < 4; i++) bit_period(1'b0, 1'b0, 8'h00);

        // Falling-edge launch, LSB first, slot 1 offset 3 (R1 R3 R5)
        frame(1'b0, 8'h00, 1'b0, 8'h00);
        // MSB first, inverted, both outputs (R5 R6 R7)
        cfg_msb_first = 1'b1; cfg_invert = 1'b1; cfg_en_b = 1'b1;
        cfg_slot = 8'd0; cfg_bit_off = 3'd0;
        frame(1'b1, 8'h3C, 1'b0, 8'h00);
        // Underrun: nothing loaded, previous byte repeats (R10)
        frame(1'b0, 8'h00, 1'b0, 8'h00);
        // Second load while full is ignored (R9)
        cfg_slot = 8'd3; cfg_bit_off = 3'd7; cfg_invert = 1'b0;
        frame(1'b1, 8'h81, 1'b1, 8'h7E);
        // Strobe mode overrides second enable (R8)
        cfg_strobe_b = 1'b1; cfg_en_b = 1'b0;
        frame(1'b1, 8'hC3, 1'b0, 8'h00);
        // Strobe with first output disabled stays high (R8, R4)
        cfg_en_a = 1'b0;
        frame(1'b1, 8'h5A, 1'b0, 8'h00);
        // Rising-edge launch (R1)
        cfg_en_a = 1'b1; cfg_strobe_b = 1'b0; cfg_en_b = 1'b1;
        cfg_launch_rise = 1'b1; cfg_slot = 8'd2; cfg_bit_off = 3'd1;
        frame(1'b1, 8'hE1, 1'b0, 8'h00);

        // Random frames
        for (int f = 0; f < 40; f++) begin
            cfg_launch_rise = 1'($urandom_range(0, 1));
            cfg_invert      = 1'($urandom_range(0, 1));
            cfg_msb_first   = 1'($urandom_range(0, 1));
            cfg_slot        = 8'($urandom_range(0, 3));
            cfg_bit_off     = 3'($urandom_range(0, 7));
            cfg_en_a        = 1'($urandom_range(0, 3) != 0);
            cfg_en_b        = 1'($urandom_range(0, 1));
            cfg_strobe_b    = 1'($urandom_range(0, 3) == 0);
            frame(1'($urandom_range(0, 3) != 0), 8'($urandom),
                  1'($urandom_range(0, 3) == 0), 8'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule